// File: doc/BRIEF.md
# Double to Wide Fixed-Point Stream Converter

This block takes one 64-bit IEEE-754 double and produces the exact two's-complement integer that equals the double's value multiplied by 2^1074. The result word is 2101 bits wide, which is enough to hold every finite double, from the smallest subnormal to the largest normal, with no rounding. Nothing is computed on the value except a left shift of the significand and, for negative inputs, a negation. A reduction engine that adds such integers can therefore sum doubles with no loss of precision and with a result that does not depend on the order of the additions.

The input is a valid/ready port. The output is never held as one wide word. It leaves as a stream of 32-bit chunks over a valid/ready port, least significant chunk first, and a last flag marks the final chunk. Each chunk is built from a small window onto the registered significand, and a one-bit borrow carries the negation from one chunk to the next. The unit accepts its next input in the same cycle that the final chunk of the current value is taken, so back-to-back values stream without a gap.

Top module: `dbl2fix_stream`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: For a normal input (exponent field 1..2046), the magnitude produced is (2^52 + fraction) shifted left by (exponent field − 1). This equals value × 2^1074.
- R3: For a subnormal input (exponent field 0, fraction nonzero), the hidden bit is 0 and the shift is 0. The magnitude equals the fraction.
- R4: When sign bit 63 is set and the input is finite, the output is the two's-complement negation of the magnitude over all 66×32 streamed bits. Bits above bit 2100 of the final chunk are copies of the sign.
- R5: Both +0 and −0 produce all-zero chunks, with out_err low.
- R6: When the exponent field is all ones (infinity or NaN), out_err is high on every chunk of that value and every data chunk is zero.
- R7: Each accepted input produces exactly 66 chunks, least significant first. out_last is high on the 66th chunk only.
- R8: While out_valid is high and out_ready is low, out_chunk, out_last and out_err hold their values into the next cycle.
- R9: While a stream is in progress, in_ready is low, except in a cycle where the final chunk is being taken. In that cycle a new input is accepted and its first chunk follows in the next cycle.
- R10: After the final chunk is taken with no new input accepted, out_valid is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input double is present |
| in_ready | output | 1 | Converter can take an input this cycle |
| in_bits | input | 64 | IEEE-754 double bit pattern |
| out_valid | output | 1 | A result chunk is present |
| out_ready | input | 1 | Consumer takes the chunk this cycle |
| out_chunk | output | 32 | Current 32-bit slice of the result, lowest first |
| out_last | output | 1 | This chunk is the most significant one |
| out_err | output | 1 | Input was infinity or NaN; data is zero |

## Verification
Two events can land in the same cycle: the final chunk of one value leaving and the next double being accepted. In that cycle the state must be reloaded instead of cleared. The bench provokes this by presenting a second double while the first value is still streaming with out_ready held high. At the moment of acceptance it checks that the final chunk handshake is also active, and the scoreboard then checks that the next chunk is chunk 0 of the new value. Random backpressure on out_ready in other phases shows that a stalled final chunk delays both the end of the stream and the acceptance of the next input.

// File: rtl/dbl2fix_stream.sv
module dbl2fix_stream #(
  parameter int CHUNK_W = 32,
  parameter int FIX_W   = 2101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [63:0]        in_bits,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [CHUNK_W-1:0] out_chunk,
  output logic               out_last,
  output logic               out_err
);
  localparam int FRAC_W  = 52;
  localparam int EXP_W   = 11;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int N_CHUNK = (FIX_W + CHUNK_W - 1) / CHUNK_W;
  localparam int IDX_W   = $clog2(N_CHUNK);
  localparam int D_W     = 16;
  localparam int WIN_W   = 2 * SIG_W + CHUNK_W;
  localparam int AMT_W   = $clog2(WIN_W);
  localparam logic signed [D_W-1:0] CW_S   = D_W'(CHUNK_W);
  localparam logic signed [D_W-1:0] NSIG_S = -D_W'(SIG_W);
  localparam logic signed [D_W-1:0] SIG_S  = D_W'(SIG_W);

  logic             busy;
  logic [IDX_W-1:0] idx;
  logic [SIG_W-1:0] sig_q;
  logic [EXP_W-1:0] sh_q;
  logic             neg_q, err_q, carry_q;

  logic [EXP_W-1:0]  exp_f;
  logic              special;
  logic              at_last, in_fire, out_fire;
  logic signed [D_W-1:0] base, d;
  logic              in_win;
  logic [AMT_W-1:0]  amt;
  logic [WIN_W-1:0]  win;
  logic [CHUNK_W-1:0] mag, neg_chunk;

  assign exp_f    = in_bits[62:52];
  assign special  = &exp_f;
  assign at_last  = idx == IDX_W'(N_CHUNK - 1);
  assign in_ready = !busy || (out_ready && at_last);
  assign in_fire  = in_valid && in_ready;
  assign out_fire = busy && out_ready;

  always_comb begin
    base   = D_W'(idx) * CW_S;
    d      = D_W'(sh_q) - base;
    in_win = (d < CW_S) && (d > NSIG_S);
    amt    = AMT_W'(d + SIG_S);
    win    = WIN_W'(sig_q) << amt;
    mag    = in_win ? win[SIG_W +: CHUNK_W] : '0;
  end

  assign neg_chunk = ~mag + CHUNK_W'(carry_q);

  assign out_valid = busy;
  assign out_last  = busy && at_last;
  assign out_err   = busy && err_q;
  assign out_chunk = (!busy || err_q) ? '0 : (neg_q ? neg_chunk : mag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      sig_q   <= '0;
      sh_q    <= '0;
      neg_q   <= 1'b0;
      err_q   <= 1'b0;
      carry_q <= 1'b0;
    end else if (in_fire) begin
      busy    <= 1'b1;
      idx     <= '0;
      sig_q   <= {|exp_f, in_bits[FRAC_W-1:0]};
      sh_q    <= (exp_f == '0) ? '0 : exp_f - 1'b1;
      neg_q   <= in_bits[63];
      err_q   <= special;
      carry_q <= 1'b1;
    end else if (out_fire) begin
      if (at_last) begin
        busy <= 1'b0;
      end else begin
        idx     <= idx + 1'b1;
        carry_q <= carry_q && (mag == '0);
      end
    end
  end
endmodule

// File: rtl/dbl2fix_stream_chk.sv
module dbl2fix_stream_chk #(
  parameter int CHUNK_W = 32,
  parameter int FIX_W   = 2101
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [63:0]        in_bits,
  input logic               out_valid,
  input logic               out_ready,
  input logic [CHUNK_W-1:0] out_chunk,
  input logic               out_last,
  input logic               out_err
);
  localparam int N_CHUNK = (FIX_W + CHUNK_W - 1) / CHUNK_W;
  localparam int CNT_W   = $clog2(N_CHUNK) + 1;

  logic [CNT_W-1:0] beat_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) beat_cnt <= '0;
    else if (out_valid && out_ready) beat_cnt <= out_last ? '0 : beat_cnt + 1'b1;
  end

  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_chunk == '0));

  // R7
  last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (beat_cnt == CNT_W'(N_CHUNK - 1)));

  // R7
  last_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && beat_cnt == CNT_W'(N_CHUNK - 1)) |-> out_last);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_chunk) && $stable(out_last) && $stable(out_err)));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> !in_ready);

  // R9
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && beat_cnt == '0));

  // R10
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && !(in_valid && in_ready)) |=> !out_valid);

  // R6
  err_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_err == $past(out_err)));
endmodule

bind dbl2fix_stream dbl2fix_stream_chk #(.CHUNK_W(CHUNK_W), .FIX_W(FIX_W)) u_chk (.*);

// File: tb/tb_dbl2fix_stream.sv
module tb_dbl2fix_stream;
  localparam int CLK_P = 10;
  localparam int CW    = 32;
  localparam int NC    = 66;
  localparam int TW    = CW * NC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [63:0] in_bits = '0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, out_last, out_err;
  logic [CW-1:0] out_chunk;

  int errors = 0;
  int checks = 0;
  bit bp = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [CW-1:0] data;
    logic          last;
    logic          err;
    string         req;
    int            beat;
  } item_t;
  item_t q[$];

  dbl2fix_stream dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bits(in_bits), .out_valid(out_valid), .out_ready(out_ready),
    .out_chunk(out_chunk), .out_last(out_last), .out_err(out_err)
  );

  always #(CLK_P/2) clk = ~clk;

  wire fire_last = out_valid && out_ready && out_last;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] ref_int(input logic [63:0] x);
    logic [10:0] e;
    logic [52:0] m;
    int s;
    logic [TW-1:0] v;
    e = x[62:52];
    if (e == 0) begin m = {1'b0, x[51:0]}; s = 0; end
    else        begin m = {1'b1, x[51:0]}; s = int'(e) - 1; end
    v = TW'(m) << s;
    if (x[63]) v = -v;
    return v;
  endfunction

  task automatic push_expect(input logic [63:0] x, input string req);
    logic [TW-1:0] v;
    bit sp;
    sp = &x[62:52];
    v = sp ? '0 : ref_int(x);
    for (int i = 0; i < NC; i++) begin
      item_t it;
      it.data = v[i*CW +: CW];
      it.last = (i == NC - 1);
      it.err  = sp;
      it.req  = req;
      it.beat = i;
      q.push_back(it);
    end
  endtask

  task automatic send(input logic [63:0] x, input string req, input bit overlap);
    @(negedge clk);
    in_valid = 1'b1;
    in_bits  = x;
    push_expect(x, req);
    forever begin
      #2;
      if (in_ready) break;
      @(negedge clk);
    end
    if (overlap)
      check(fire_last, "R9", "accept not in final-beat cycle", CW'(fire_last), 32'h1);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      out_ready <= bp ? ($urandom_range(0, 2) != 0) : 1'b1;
      #1;
      if (out_valid && !out_last)
        check(!in_ready, "R9", "in_ready high mid-stream", CW'(in_ready), 32'h0);
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R7", "chunk with empty scoreboard", out_chunk, 32'h0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(out_chunk === it.data, it.req, $sformatf("data beat %0d", it.beat),
                out_chunk, it.data);
          check(out_last === it.last, "R7", $sformatf("last beat %0d", it.beat),
                CW'(out_last), CW'(it.last));
          check(out_err === it.err, "R6", $sformatf("err beat %0d", it.beat),
                CW'(out_err), CW'(it.err));
        end
      end else if (out_valid && !out_ready) begin
        logic [CW-1:0] d0;
        logic l0, e0;
        d0 = out_chunk; l0 = out_last; e0 = out_err;
        @(posedge clk); #1;
        check(out_valid && out_chunk === d0 && out_last === l0 && out_err === e0,
              "R8", "output changed under stall", out_chunk, d0);
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;
    check(!out_valid, "R1", "out_valid after reset", CW'(out_valid), 32'h0);
    check(in_ready, "R1", "in_ready after reset", CW'(in_ready), 32'h1);

    bp = 1'b1;
    send(64'h3FF0000000000000, "R2", 0);
    send(64'h400C000000000000, "R2", 0);
    send(64'h7FEFFFFFFFFFFFFF, "R2", 0);
    send(64'h0010000000000000, "R2", 0);
    send(64'h0000000000000001, "R3", 0);
    send(64'h000FFFFFFFFFFFFF, "R3", 0);
    send(64'hBFF0000000000000, "R4", 0);
    send(64'hFFEFFFFFFFFFFFFF, "R4", 0);
    send(64'h8000000000000001, "R4", 0);
    send(64'h0000000000000000, "R5", 0);
    send(64'h8000000000000000, "R5", 0);
    send(64'h7FF0000000000000, "R6", 0);
    send(64'h7FF8000000000001, "R6", 0);
    send(64'hFFF0000000000000, "R6", 0);
    for (int k = 0; k < 6; k++) begin
      logic [63:0] r;
      r = {$urandom, $urandom};
      if (&r[62:52]) r[62] = 1'b0;
      send(r, r[63] ? "R4" : "R2", 0);
    end
    wait (q.size() == 0);

    bp = 1'b0;
    @(negedge clk);
    send(64'h4000000000000000, "R2", 0);
    send(64'hC1D0000000000123, "R4", 1);
    send(64'h7FF0000000000000, "R6", 1);
    send(64'h8000000000000000, "R5", 1);
    wait (q.size() == 0);
    @(negedge clk); #2;
    check(!out_valid, "R10", "out_valid after drain", CW'(out_valid), 32'h0);
    check(in_ready, "R10", "in_ready after drain", CW'(in_ready), 32'h1);

    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule